// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block produces the 16x-oversampling enable for a 16550-style serial port. The total divisor is the input clock divided by sixteen times the baud rate. It has a 16-bit integer part (the quotient) and an N-bit fractional part. The fraction register holds the fractional part scaled by 2^N. The average spacing between enables is therefore quotient + fraction / 2^N clocks, so baud rates that do not divide the clock evenly can still be met on average.

Each enable period, an N-bit accumulator adds the fraction. A period that produces a carry out of the accumulator lasts one extra clock. Software programs the fraction first and the quotient second, through a small register port. Software can find N by writing all ones to the fraction register and reading it back: only the implemented low bits keep their value. When N is zero, the fraction register reads as zero and the generator divides by the quotient alone.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `tick` is low and both registers read back as zero (select 0 = quotient, select 1 = fraction).
- R2: While the quotient is zero, `tick` never asserts, whatever the fraction holds.
- R3: With a fraction of zero and a quotient Q of 1 or more, every enable period is exactly Q clocks, the same as a plain integer divider.
- R4: With a fraction F, each period lasts Q+1 clocks when adding F to the N-bit accumulator carries out, and Q clocks otherwise. The accumulator starts at zero after any register write.
- R5: Over 2^N consecutive periods after a write, the total clock count equals Q*2^N + F exactly.
- R6: A fraction write keeps only its N low bits. After writing all ones, the readback equals 2^N-1, and every bit from position N upward reads zero.
- R7: The quotient register stores and returns all 16 bits. Read data is registered: it appears in the cycle after the read strobe, and `rdata` is zero in a cycle that follows no read strobe.
- R8: A write to either register restarts timing. `tick` is low in the cycle after the write. The first period then starts from the write edge and lasts Q clocks, because the first accumulation never carries.
- R9: `tick` is a single-cycle pulse: when Q is 2 or more, it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel | input | 1 | Register select: 0 quotient, 1 fraction |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| tick | output | 1 | One-cycle oversampling enable |

## Verification
A corrupted accumulator or period counter shows up at the ports as a wrong gap between two `tick` pulses. It appears no later than the next period end, at most Q+1 clocks after the fault. Slow drift from a wrong carry pattern, which individual gaps can hide, shows up as a mismatch in the total over 2^N periods. A stale or wide fraction register shows up on the very next readback as bits above N, or as a value that differs from what was written.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  typedef enum logic [0:0] {
    SEL_QUOT = 1'b0,
    SEL_FRAC = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
  import frac_baud_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4,
  parameter int DATA_W = 16,
  localparam int FW_EFF = (FRAC_W > 0) ? FRAC_W : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [INT_W-1:0]  quot_o,
  output logic [FW_EFF-1:0] frac_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              restart_o
);
  logic [INT_W-1:0]  quot_q;
  logic [DATA_W-1:0] frac_rd;
  logic              sel_frac;

  assign sel_frac  = (reg_sel_e'(sel) == SEL_FRAC);
  assign restart_o = wr_en;
  assign quot_o    = quot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      quot_q <= '0;
    end else if (wr_en && !sel_frac) begin
      quot_q <= wdata[INT_W-1:0];
    end
  end

  generate
    if (FRAC_W > 0) begin : g_frac
      logic [FRAC_W-1:0] frac_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          frac_q <= '0;
        end else if (wr_en && sel_frac) begin
          frac_q <= wdata[FRAC_W-1:0];
        end
      end
      assign frac_o  = frac_q;
      assign frac_rd = DATA_W'(frac_q);
    end else begin : g_nofrac
      assign frac_o  = '0;
      assign frac_rd = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_en) begin
      rdata_o <= sel_frac ? frac_rd : DATA_W'(quot_q);
    end else begin
      rdata_o <= '0;
    end
  end
endmodule

// File: rtl/frac_baud_accum.sv
module frac_baud_accum #(
  parameter int FRAC_W = 4,
  localparam int FW_EFF = (FRAC_W > 0) ? FRAC_W : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              advance,
  input  logic [FW_EFF-1:0] frac,
  output logic              carry_o
);
  generate
    if (FRAC_W > 0) begin : g_acc
      logic [FRAC_W-1:0] acc_q;
      logic [FRAC_W:0]   sum;
      assign sum     = {1'b0, acc_q} + {1'b0, frac};
      assign carry_o = sum[FRAC_W];
      always_ff @(posedge clk) begin
        if (rst || clear) begin
          acc_q <= '0;
        end else if (advance) begin
          acc_q <= sum[FRAC_W-1:0];
        end
      end
    end else begin : g_noacc
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst, clear, advance, frac};
      assign carry_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/frac_baud_counter.sv
module frac_baud_counter #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [INT_W-1:0] quot,
  input  logic             carry,
  output logic             advance_o,
  output logic             tick_o
);
  logic [INT_W-1:0] cnt_q;
  logic [INT_W:0]   last;
  logic             running;
  logic             at_end;

  assign running   = (quot != '0);
  assign last      = {1'b0, quot} - (INT_W+1)'(1) + (INT_W+1)'(carry);
  assign at_end    = running && ({1'b0, cnt_q} == last);
  assign advance_o = at_end && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!running) begin
      tick_o <= 1'b0;
    end else if (at_end) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tick
);
  localparam int FW_EFF = (FRAC_W > 0) ? FRAC_W : 1;

  logic [INT_W-1:0]  quot_w;
  logic [FW_EFF-1:0] frac_w;
  logic              restart_w;
  logic              carry_w;
  logic              advance_w;

  frac_baud_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .wdata(wdata), .quot_o(quot_w), .frac_o(frac_w), .rdata_o(rdata),
    .restart_o(restart_w)
  );

  frac_baud_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst(rst), .clear(restart_w), .advance(advance_w),
    .frac(frac_w), .carry_o(carry_w)
  );

  frac_baud_counter #(.INT_W(INT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart_w), .quot(quot_w),
    .carry(carry_w), .advance_o(advance_w), .tick_o(tick)
  );
endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              sel,
  input logic              tick,
  input logic [DATA_W-1:0] rdata,
  input logic [INT_W-1:0]  quot
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!tick && rdata == '0));

  assert_idle_zero_quot_R2: assert property (@(posedge clk) disable iff (rst)
    (quot == '0) |=> !tick);

  assert_frac_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel) |=> ((rdata >> FRAC_W) == '0));

  assert_rdata_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tick);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && quot >= INT_W'(2)) |=> !tick);
endmodule

bind frac_baud_gen frac_baud_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
  .tick(tick), .rdata(rdata), .quot(quot_w)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  localparam int N  = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic          sel = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          tick;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int elapsed = 0;
  int sum_obs = 0;
  int ticks_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frac_baud_gen #(.INT_W(16), .FRAC_W(N), .DATA_W(DW)) u_frac_baud_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .wdata(wdata), .rdata(rdata), .tick(tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: measures gaps between ticks and compares against scoreboard
  always @(posedge clk) begin
    #1;
    if (rst) begin
      elapsed = 0;
    end else if (wr_en) begin
      elapsed = 0;
      exp_q.delete();
    end else begin
      elapsed++;
      if (tick) begin
        ticks_seen++;
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          chk(elapsed == e, "R4 period length", elapsed, e);
          sum_obs += elapsed;
        end
        elapsed = 0;
      end
    end
  end

  task automatic wr(input logic s, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, input int expv, input string req);
    @(negedge clk);
    rd_en = 1'b1; sel = s;
    @(negedge clk);
    rd_en = 1'b0;
    chk(int'(rdata) == expv, req, int'(rdata), expv);
  endtask

  // driver: program divisor and push the modelled period lengths
  task automatic run(input int q, input int f, input string req);
    int acc = 0;
    int mask = (1 << N) - 1;
    wr(1'b1, DW'(f));
    wr(1'b0, DW'(q));
    sum_obs = 0;
    for (int i = 0; i < (1 << N); i++) begin
      int s;
      s = acc + (f & mask);
      exp_q.push_back(q + (s >> N));
      acc = s & mask;
    end
    for (int c = 0; c < 5000 && exp_q.size() > 0; c++) @(negedge clk);
    chk(exp_q.size() == 0, {req, " scoreboard drained"}, exp_q.size(), 0);
    chk(sum_obs == q * (1 << N) + (f & mask), "R5 total over 2^N periods",
        sum_obs, q * (1 << N) + (f & mask));
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(tick == 1'b0, "R1 tick low after reset", int'(tick), 0);
    rd(1'b0, 0, "R1 quotient reads zero");
    rd(1'b1, 0, "R1 fraction reads zero");
    begin
      int t0 = ticks_seen;
      repeat (40) @(negedge clk);
      chk(ticks_seen == t0, "R2 no tick with zero quotient after reset", ticks_seen - t0, 0);
    end
    rd(1'b1, 0, "R7 read data zero on idle select");
    @(negedge clk);
    chk(rdata == '0, "R7 rdata zero without read strobe", int'(rdata), 0);
    wr(1'b0, 16'hBEEF);
    rd(1'b0, 16'hBEEF, "R7 quotient full width readback");
    wr(1'b1, 16'hFFFF);
    rd(1'b1, (1 << N) - 1, "R6 fraction all-ones readback");
    wr(1'b0, 16'h0000);
    begin
      int t0 = ticks_seen;
      repeat (60) @(negedge clk);
      chk(ticks_seen == t0, "R2 no tick with zero quotient and nonzero fraction", ticks_seen - t0, 0);
    end
    run(5, 0, "R3 zero fraction q5");
    run(5, 3, "R4 q5 f3");
    run(7, 8, "R4 q7 f8");
    run(2, 1, "R4 q2 f1");
    run(1, 15, "R4 q1 f15");
    run(3, 15, "R4 q3 f15");
    run(1, 0, "R3 q1 f0");
    // R8: restart mid-period; the first period is Q clocks from the write
    wr(1'b0, 16'd9);
    repeat (4) @(negedge clk);
    run(6, 5, "R8 restart mid-period");
    wr(1'b0, 16'd0);
    done = 1'b1;
    finish_up();
  end
endmodule